// File: doc/BRIEF.md
# Eight-Bit Addressable Latch and Line Decoder

This block holds eight single-bit storage cells that share one serial data bit. A 3-bit address picks one cell. An active-low enable lets the data bit into the picked cell. An active-low clear input either wipes the whole bank or, when enable is also low, turns the block into a 3-to-8 line decoder: the addressed output carries the data bit and every other output is low.

The block is a synchronous equivalent of a level-sensitive latch bank. All inputs are sampled on the rising clock edge, and the eight outputs come straight from registers. Each output therefore shows the effect of a given input state one clock after that state was sampled. A synchronous, active-high reset clears the bank. Moving the address while enable is low is well defined here. On each edge the cell that is addressed at that edge is written, and a cell written earlier keeps what it received.

Top module: `addr_latch8`

## Requirements
- R1: An address value k, with addr[2] as the most significant bit, selects output q[k]. Address 0 selects q[0] and address 7 selects q[7].
- R2: With en_n=0 and clr_n=1 at a rising edge, the addressed output takes din after that edge and all other outputs keep their values.
- R3: Once en_n returns high, the addressed output keeps the last value written into it while enable was low.
- R4: With en_n=1 and clr_n=1 at a rising edge, no output changes, whatever din and addr are.
- R5: With en_n=1 and clr_n=0 at a rising edge, all eight outputs are 0 after that edge.
- R6: With en_n=0 and clr_n=0 at a rising edge, q becomes (1 << addr) when din=1 and 0 when din=0.
- R7: With rst=1 at a rising edge, all outputs are 0 after that edge, whatever the other inputs are.
- R8: If addr changes while en_n stays low and clr_n stays high, each edge writes din into the cell addressed at that edge, and a cell written earlier keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Shared data bit |
| addr | input | 3 | Cell select; addr[2] is the most significant bit |
| en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low clear / decoder select |
| q | output | 8 | Registered cell outputs, q[k] belongs to address k |

## Verification
Every result is due exactly one rising edge after the input state that causes it, because q is the only register between the inputs and the outputs. The bench changes the inputs one time unit after an edge and compares q one time unit after the next edge, so that edge is the only one the reference has to account for. The reference model steps once per edge with the same applied values. A near-exhaustive sweep covers every mode, address and data value from three different stored patterns. Directed sequences cover the hold after enable rises, address moves with enable low, and reset, and a random run follows them.

// File: rtl/addr_latch8.sv
module addr_latch8 #(
  parameter int ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   din,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   en_n,
  input  logic                   clr_n,
  output logic [(1<<ADDR_W)-1:0] q
);
  localparam int N = 1 << ADDR_W;

  logic [N-1:0] sel;
  logic [N-1:0] keep;
  logic [N-1:0] put;

  // one-hot cell select, addr MSB is the high address line
  assign sel  = {{(N-1){1'b0}}, 1'b1} << addr;
  // bits that survive the edge: all in hold, the unaddressed ones in write, none when clearing
  assign keep = clr_n ? (en_n ? {N{1'b1}} : ~sel) : {N{1'b0}};
  // bits loaded from din: only the addressed one, only while enabled
  assign put  = en_n ? {N{1'b0}} : (sel & {N{din}});

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & keep) | put;
  end
endmodule

// File: rtl/addr_latch8_chk.sv
module addr_latch8_chk #(
  parameter int ADDR_W = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   din,
  input logic [ADDR_W-1:0]      addr,
  input logic                   en_n,
  input logic                   clr_n,
  input logic [(1<<ADDR_W)-1:0] q
);
  localparam int N = 1 << ADDR_W;
  logic [N-1:0] onehot;
  always_comb begin
    onehot = '0;
    for (int k = 0; k < N; k++) if (addr == k) onehot[k] = 1'b1;
  end

  a_r7_reset_clears: assert property (@(posedge clk) rst |=> q == '0);

  a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (en_n && clr_n) |=> $stable(q));

  a_r5_clear_all: assert property (@(posedge clk) disable iff (rst)
    (en_n && !clr_n) |=> q == '0);

  // R2 and R8: only the addressed cell may change, and it takes din
  a_r2_write_others_kept: assert property (@(posedge clk) disable iff (rst)
    (!en_n && clr_n) |=> (q & ~$past(onehot)) == ($past(q) & ~$past(onehot)));

  a_r2_write_addressed: assert property (@(posedge clk) disable iff (rst)
    (!en_n && clr_n) |=> ((q & $past(onehot)) != '0) == $past(din));

  a_r6_decoder_pattern: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr_n) |=> q == ($past(din) ? $past(onehot) : '0));

  a_r6_decoder_onehot0: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr_n) |=> $onehot0(q));
endmodule

bind addr_latch8 addr_latch8_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .din(din), .addr(addr),
  .en_n(en_n), .clr_n(clr_n), .q(q)
);

// File: tb/sim_addr_latch8.sv
module sim_addr_latch8;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic [2:0] addr = '0;
  logic       en_n = 1'b1;
  logic       clr_n = 1'b1;
  logic [7:0] q;
  logic [7:0] exp_q = '0;
  int checks = 0;
  int errors = 0;

  addr_latch8 u0 (.clk(clk), .rst(rst), .din(din), .addr(addr),
                  .en_n(en_n), .clr_n(clr_n), .q(q));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // reference step from the mode table
  function automatic logic [7:0] model(input logic [7:0] cur, input logic r, input logic d,
                                       input logic [2:0] a, input logic e, input logic c);
    logic [7:0] nxt;
    if (r) return 8'h00;
    for (int k = 0; k < 8; k++) begin
      if (!e && a == k)   nxt[k] = d;
      else if (!c)        nxt[k] = 1'b0;
      else                nxt[k] = cur[k];
    end
    return nxt;
  endfunction

  // apply one input state, let one edge pass, compare
  task automatic cyc(input logic d, input logic [2:0] a, input logic e, input logic c);
    string tag;
    din = d; addr = a; en_n = e; clr_n = c;
    @(posedge clk); #1;
    exp_q = model(exp_q, 1'b0, d, a, e, c);
    case ({e, c})
      2'b01:   tag = "R2 write";
      2'b11:   tag = "R4 hold";
      2'b10:   tag = "R5 clear";
      default: tag = "R6 decode";
    endcase
    chk(tag, q, exp_q);
  endtask

  task automatic load(input logic [7:0] pat);
    cyc(1'b0, 3'd0, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) cyc(pat[k], 3'(k), 1'b0, 1'b1);
    cyc(1'b0, 3'd0, 1'b1, 1'b1);
  endtask

  initial begin
    #(PERIOD*100000);
    errors++;
    $display("FAIL watchdog: q=%b expected completion", q);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pats [3];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
    din = 1'b1; addr = 3'd5; en_n = 1'b0; clr_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R7 reset with write active", q, 8'h00);
    rst = 1'b0;
    cyc(1'b0, 3'd0, 1'b1, 1'b1);

    // R1: each address lands on its own bit
    for (int k = 0; k < 8; k++) begin
      cyc(1'b0, 3'd0, 1'b1, 1'b0);
      cyc(1'b1, 3'(k), 1'b0, 1'b1);
      chk("R1 address map", q, 8'(1 << k));
    end

    // sweep: every stored pattern x mode x address x data
    foreach (pats[p])
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 8; a++)
          for (int d = 0; d < 2; d++) begin
            load(pats[p]);
            cyc(1'(d), 3'(a), m[1], m[0]);
          end

    // R3: written value held once enable rises, despite din/addr toggling
    load(8'h00);
    cyc(1'b1, 3'd5, 1'b0, 1'b1);
    for (int k = 0; k < 8; k++) begin
      cyc(1'(k & 1), 3'(k), 1'b1, 1'b1);
      chk("R3 captured value held", q, 8'h20);
    end

    // R8: address moves with enable low
    load(8'h00);
    cyc(1'b1, 3'd2, 1'b0, 1'b1);
    cyc(1'b0, 3'd6, 1'b0, 1'b1);
    chk("R8 moved address, old bit kept", q, 8'h04);
    cyc(1'b1, 3'd7, 1'b0, 1'b1);
    chk("R8 moved address, new bit written", q, 8'h84);

    // R6 explicit decoder values
    load(8'hFF);
    cyc(1'b1, 3'd3, 1'b0, 1'b0);
    chk("R6 decoder one-hot", q, 8'h08);
    cyc(1'b0, 3'd3, 1'b0, 1'b0);
    chk("R6 decoder din low", q, 8'h00);

    // random run
    for (int i = 0; i < 3000; i++)
      cyc(1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));

    // R7 mid-run reset
    load(8'h5A);
    rst = 1'b1; din = 1'b1; addr = 3'd1; en_n = 1'b0; clr_n = 1'b1;
    @(posedge clk); #1;
    exp_q = 8'h00;
    chk("R7 mid-run reset", q, 8'h00);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule